// File: doc/BRIEF.md
# Dual-Channel Priority Resolver with Rearm

This block picks one interrupt line out of up to three banks of lines (32 each by default) for each of two request channels, a normal channel and a fast channel. A line competes on a channel when it is pending, not masked, and steered to that channel. Among the competing lines the smallest priority value wins. On equal priority the line with the larger line number wins. The winner's line number is held in a per-channel register, and a per-channel interrupt output is raised.

Each channel fires once and then waits. After it has fired, further evaluations leave its output and its line number alone until software sends a rearm pulse for that channel. The rearm drops the output, arms the channel again and starts a fresh evaluation. The capture logic pulses an evaluate strobe whenever a new interrupt is latched or a mask changes, and that strobe makes both channels evaluate.

A global mask input can hold back firing while leaving the channel armed. Register decoding and input capture belong to the surrounding logic.

Top module: `dual_prio_resolver`

## Requirements
- R1: A line competes on the normal channel when its pending bit is 1, its mask bit is 0 and its steering bit is 0. It competes on the fast channel under the same conditions with the steering bit at 1.
- R2: Among the competing lines of a channel, the line with the numerically smallest priority value wins. Value 0 is the most urgent.
- R3: When competing lines share the smallest priority value, the one with the largest line number wins.
- R4: The reported line number is bank*BANK_LINES + bit. With the default of 32 lines per bank, line `n` sits at bit `n` of the flat vectors, and its priority is field `prio_i[n*PRIO_W +: PRIO_W]`.
- R5: A channel fires only while it is armed. Firing latches the winner, raises the output and disarms the channel. Later evaluations leave the output and the line number unchanged until a rearm.
- R6: A rearm pulse for a channel drives its output low on the next cycle and sets it armed. It also starts an evaluation, and if a line competes, the output is high and the new line number is visible two cycles after the pulse.
- R7: An evaluate pulse starts an evaluation on both channels. Pending lines that appear without an evaluate or rearm pulse do not fire a channel.
- R8: While the global mask input is 1 at evaluation time, no channel fires and an armed channel stays armed. A later evaluation with the mask at 0 fires it.
- R9: After reset both outputs are low, both line numbers are 0 and both channels are armed.
- R10: Lines in banks numbered NUM_BANKS and above never compete.
- R11: A channel's line number changes only in the cycle its output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 3*BANK_LINES | Pending bit per line |
| mask_i | input | 3*BANK_LINES | Mask bit per line, 1 blocks the line |
| steer_i | input | 3*BANK_LINES | Channel steering per line, 1 selects the fast channel |
| prio_i | input | 3*BANK_LINES*PRIO_W | Priority value per line, lower is more urgent |
| gmask_i | input | 1 | Global mask, 1 holds back firing |
| eval_i | input | 1 | Evaluate strobe for both channels |
| rearm_irq_i | input | 1 | Rearm pulse for the normal channel |
| rearm_fiq_i | input | 1 | Rearm pulse for the fast channel |
| irq_o | output | 1 | Normal channel interrupt, sticky until rearm |
| fiq_o | output | 1 | Fast channel interrupt, sticky until rearm |
| irq_line_o | output | clog2(3*BANK_LINES) | Latched winner of the normal channel |
| fiq_line_o | output | clog2(3*BANK_LINES) | Latched winner of the fast channel |

## Verification
The hardest case to reach is an evaluation that finds the channel disarmed, or held back by the global mask, while a better line is competing. A correct design keeps the old line number there, and a faulty one replaces it quietly. The stimulus first fires a channel, then raises a more urgent line and pulses the evaluate strobe without a rearm. It then repeats the sequence with the global mask set before arming, and clears the mask and evaluates again. Around these cases it sweeps each of the 96 line positions one at a time, all 64 priority pairs of two fixed lines, and uniform priority levels for ties. The bench predicts every winner with an arithmetic scan of its own.

// File: rtl/prio_res_pkg.sv
`timescale 1ns/1ps
package prio_res_pkg;
   // Largest number of banks the port vectors are sized for.
   localparam int MAX_BANKS = 3;
   // Number of request channels.
   localparam int NUM_CH = 2;

   typedef enum logic {
      CH_IRQ = 1'b0,
      CH_FIQ = 1'b1
   } chan_e;
endpackage

// File: rtl/prio_res_elig.sv
`timescale 1ns/1ps
module prio_res_elig
   import prio_res_pkg::*;
#(
   parameter int    N  = 96,
   parameter chan_e CH = CH_IRQ
) (
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] mask_i,
   input  logic [N-1:0] steer_i,
   output logic [N-1:0] elig_o
);
   // The channel parameter picks which steering polarity is accepted.
   if (CH == CH_FIQ) begin : g_fast
      assign elig_o = pend_i & ~mask_i & steer_i;
   end else begin : g_norm
      assign elig_o = pend_i & ~mask_i & ~steer_i;
   end
endmodule

// File: rtl/prio_res_tree.sv
`timescale 1ns/1ps
module prio_res_tree #(
   parameter int N  = 96,
   parameter int PW = 6,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]    elig_i,
   input  logic [N*PW-1:0] prio_i,
   output logic            any_o,
   output logic [IW-1:0]   idx_o
);
   // The tree is padded to a power of two. Leaves sit at NP-1..2*NP-2 in heap order,
   // so the left child always covers lower line numbers than the right child.
   localparam int NP    = 1 << IW;
   localparam int NODES = 2 * NP - 1;

   if (NP < N) begin : g_bad_width
      $error("prio_res_tree: IW too small for N");
   end

   logic          nv   [NODES];
   logic [PW-1:0] npri [NODES];
   logic [IW-1:0] nidx [NODES];

   for (genvar i = 0; i < NP; i++) begin : g_leaf
      if (i < N) begin : g_real
         assign nv[NP-1+i]   = elig_i[i];
         assign npri[NP-1+i] = prio_i[i*PW +: PW];
      end else begin : g_pad
         assign nv[NP-1+i]   = 1'b0;
         assign npri[NP-1+i] = '0;
      end
      assign nidx[NP-1+i] = IW'(i);
   end

   // Right child wins on a priority tie, which gives the larger line number.
   for (genvar k = 0; k < NP - 1; k++) begin : g_node
      logic take_r;
      assign take_r  = nv[2*k+2] && (!nv[2*k+1] || (npri[2*k+2] <= npri[2*k+1]));
      assign nv[k]   = nv[2*k+1] | nv[2*k+2];
      assign npri[k] = take_r ? npri[2*k+2] : npri[2*k+1];
      assign nidx[k] = take_r ? nidx[2*k+2] : nidx[2*k+1];
   end

   assign any_o = nv[0];
   assign idx_o = nv[0] ? nidx[0] : '0;
endmodule

// File: rtl/prio_res_chan.sv
`timescale 1ns/1ps
module prio_res_chan #(
   parameter int IDX_W  = 7,
   parameter int LINE_W = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              trig_i,
   input  logic              rearm_i,
   input  logic              any_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              gmask_i,
   output logic              out_o,
   output logic [LINE_W-1:0] line_o
);
   // Stage one captures the resolved winner, stage two commits it.
   logic             s1_trig;
   logic             s1_any;
   logic             s1_gm;
   logic [IDX_W-1:0] s1_idx;
   logic             armed;
   logic             commit;

   assign commit = s1_trig && armed && s1_any && !s1_gm;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_trig <= 1'b0;
         s1_any  <= 1'b0;
         s1_gm   <= 1'b0;
         s1_idx  <= '0;
      end else begin
         s1_trig <= trig_i;
         s1_any  <= any_i;
         s1_gm   <= gmask_i;
         s1_idx  <= idx_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed  <= 1'b1;
         out_o  <= 1'b0;
         line_o <= '0;
      end else if (rearm_i) begin
         armed  <= 1'b1;
         out_o  <= 1'b0;
      end else if (commit) begin
         armed  <= 1'b0;
         out_o  <= 1'b1;
         line_o <= LINE_W'(s1_idx);
      end
   end
endmodule

// File: rtl/dual_prio_resolver.sv
`timescale 1ns/1ps
module dual_prio_resolver
   import prio_res_pkg::*;
#(
   parameter int NUM_BANKS  = 3,
   parameter int BANK_LINES = 32,
   parameter int PRIO_W     = 6,
   localparam int PL        = MAX_BANKS * BANK_LINES,
   localparam int LINE_W    = $clog2(PL)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [PL-1:0]        pend_i,
   input  logic [PL-1:0]        mask_i,
   input  logic [PL-1:0]        steer_i,
   input  logic [PL*PRIO_W-1:0] prio_i,
   input  logic                 gmask_i,
   input  logic                 eval_i,
   input  logic                 rearm_irq_i,
   input  logic                 rearm_fiq_i,
   output logic                 irq_o,
   output logic                 fiq_o,
   output logic [LINE_W-1:0]    irq_line_o,
   output logic [LINE_W-1:0]    fiq_line_o
);
   localparam int NL    = NUM_BANKS * BANK_LINES;
   localparam int IDX_W = $clog2(NL);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("dual_prio_resolver: NUM_BANKS must be 1..3");
   end
   if (BANK_LINES < 2) begin : g_bad_lines
      $error("dual_prio_resolver: BANK_LINES must be at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("dual_prio_resolver: PRIO_W must be 1..8");
   end

   logic [NUM_CH-1:0] rearm_v;
   logic [NUM_CH-1:0] out_v;
   logic [LINE_W-1:0] line_v [NUM_CH];

   assign rearm_v = {rearm_fiq_i, rearm_irq_i};

   // Only the active banks feed the trees, so upper banks never compete.
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [NL-1:0]    elig;
      logic             any;
      logic [IDX_W-1:0] idx;

      prio_res_elig #(
         .N  (NL),
         .CH (chan_e'(c))
      ) u_elig (
         .pend_i  (pend_i[NL-1:0]),
         .mask_i  (mask_i[NL-1:0]),
         .steer_i (steer_i[NL-1:0]),
         .elig_o  (elig)
      );

      prio_res_tree #(
         .N  (NL),
         .PW (PRIO_W),
         .IW (IDX_W)
      ) u_tree (
         .elig_i (elig),
         .prio_i (prio_i[NL*PRIO_W-1:0]),
         .any_o  (any),
         .idx_o  (idx)
      );

      prio_res_chan #(
         .IDX_W  (IDX_W),
         .LINE_W (LINE_W)
      ) u_chan (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .trig_i  (eval_i | rearm_v[c]),
         .rearm_i (rearm_v[c]),
         .any_i   (any),
         .idx_i   (idx),
         .gmask_i (gmask_i),
         .out_o   (out_v[c]),
         .line_o  (line_v[c])
      );
   end

   assign irq_o      = out_v[CH_IRQ];
   assign fiq_o      = out_v[CH_FIQ];
   assign irq_line_o = line_v[CH_IRQ];
   assign fiq_line_o = line_v[CH_FIQ];
endmodule

// File: rtl/dual_prio_resolver_chk.sv
`timescale 1ns/1ps
module dual_prio_resolver_chk #(
   parameter int NUM_BANKS  = 3,
   parameter int BANK_LINES = 32,
   parameter int PL         = 96,
   parameter int LINE_W     = 7
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [PL-1:0]     pend_i,
   input logic [PL-1:0]     mask_i,
   input logic [PL-1:0]     steer_i,
   input logic              gmask_i,
   input logic              eval_i,
   input logic              rearm_irq_i,
   input logic              rearm_fiq_i,
   input logic              irq_o,
   input logic              fiq_o,
   input logic [LINE_W-1:0] irq_line_o,
   input logic [LINE_W-1:0] fiq_line_o
);
   localparam int NL = NUM_BANKS * BANK_LINES;

   // Delayed copies of the candidate sets, two cycles deep to match the pipeline.
   logic [PL-1:0] ei_d1, ei_d2, ef_d1, ef_d2;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ei_d1 <= '0; ei_d2 <= '0; ef_d1 <= '0; ef_d2 <= '0;
      end else begin
         ei_d1 <= pend_i & ~mask_i & ~steer_i;
         ef_d1 <= pend_i & ~mask_i & steer_i;
         ei_d2 <= ei_d1;
         ef_d2 <= ef_d1;
      end
   end

   assert_irq_winner_eligible_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> ei_d2[irq_line_o]);
   assert_fiq_winner_eligible_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fiq_o) |-> ef_d2[fiq_line_o]);

   assert_irq_drop_on_rearm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rearm_irq_i |=> !irq_o);
   assert_fiq_drop_on_rearm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rearm_fiq_i |=> !fiq_o);

   assert_irq_needs_trigger_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(eval_i || rearm_irq_i, 2));
   assert_fiq_needs_trigger_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fiq_o) |-> $past(eval_i || rearm_fiq_i, 2));

   assert_irq_gmask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> !$past(gmask_i, 2));
   assert_fiq_gmask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fiq_o) |-> !$past(gmask_i, 2));

   assert_irq_line_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(irq_line_o) < NL);
   assert_fiq_line_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(fiq_line_o) < NL);

   assert_irq_line_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> $stable(irq_line_o));
   assert_fiq_line_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fiq_o |=> $stable(fiq_line_o));

   assert_irq_line_moves_on_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(irq_line_o) |-> $rose(irq_o));
   assert_fiq_line_moves_on_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(fiq_line_o) |-> $rose(fiq_o));
endmodule

bind dual_prio_resolver dual_prio_resolver_chk #(
   .NUM_BANKS  (NUM_BANKS),
   .BANK_LINES (BANK_LINES),
   .PL         (PL),
   .LINE_W     (LINE_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pend_i      (pend_i),
   .mask_i      (mask_i),
   .steer_i     (steer_i),
   .gmask_i     (gmask_i),
   .eval_i      (eval_i),
   .rearm_irq_i (rearm_irq_i),
   .rearm_fiq_i (rearm_fiq_i),
   .irq_o       (irq_o),
   .fiq_o       (fiq_o),
   .irq_line_o  (irq_line_o),
   .fiq_line_o  (fiq_line_o)
);

// File: tb/dual_prio_resolver_tb.sv
`timescale 1ns/1ps
module dual_prio_resolver_tb;
   localparam int NB  = 2;
   localparam int BL  = 32;
   localparam int PW  = 3;
   localparam int PL  = 3 * BL;
   localparam int NL  = NB * BL;
   localparam int LW  = 7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [PL-1:0]  pend = '0, mask = '0, steer = '0;
   logic [PL*PW-1:0] prio = '0;
   logic           gm = 1'b0, ev = 1'b0, rq = 1'b0, rf = 1'b0;
   logic           irq, fiq;
   logic [LW-1:0]  irq_line, fiq_line;

   int tests = 0;
   int fails = 0;
   logic [1:0] m_armed;
   logic [1:0] m_out;
   int         m_line [2];

   dual_prio_resolver #(.NUM_BANKS(NB), .BANK_LINES(BL), .PRIO_W(PW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask), .steer_i(steer),
      .prio_i(prio), .gmask_i(gm), .eval_i(ev), .rearm_irq_i(rq), .rearm_fiq_i(rf),
      .irq_o(irq), .fiq_o(fiq), .irq_line_o(irq_line), .fiq_line_o(fiq_line));

   always #5 clk = ~clk;

   initial begin
      #2000000;
      fails++;
      $display("FAIL R9 watchdog: act=timeout exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // Arithmetic reference: upward scan, later line replaces on equal priority.
   function automatic int model(input int ch);
      int best = -1;
      int bp = 1 << 20;
      for (int i = 0; i < NL; i++) begin
         if (pend[i] && !mask[i] && (int'(steer[i]) == ch)) begin
            int p = int'(prio[i*PW +: PW]);
            if (p <= bp) begin
               bp = p;
               best = i;
            end
         end
      end
      return best;
   endfunction

   function automatic int dut_out(input int c);
      return (c == 0) ? int'(irq) : int'(fiq);
   endfunction

   function automatic int dut_line(input int c);
      return (c == 0) ? int'(irq_line) : int'(fiq_line);
   endfunction

   // Called at a falling edge; returns at the falling edge two cycles later.
   task automatic pulse(input logic e, input logic r0, input logic r1, input string req);
      logic [1:0] rr;
      logic [1:0] tr;
      int m;
      rr = {r1, r0};
      tr = {r1 | e, r0 | e};
      ev = e; rq = r0; rf = r1;
      @(negedge clk);
      ev = 1'b0; rq = 1'b0; rf = 1'b0;
      for (int c = 0; c < 2; c++) begin
         if (rr[c]) begin
            chk("R6 drop after rearm", dut_out(c), 0);
            m_armed[c] = 1'b1;
            m_out[c] = 1'b0;
         end
      end
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
         if (tr[c]) begin
            m = model(c);
            if (m_armed[c] && m >= 0 && !gm) begin
               m_armed[c] = 1'b0;
               m_out[c] = 1'b1;
               m_line[c] = m;
            end
         end
         chk(req, dut_out(c), int'(m_out[c]));
         chk(req, dut_line(c), m_line[c]);
      end
   endtask

   task automatic clear_lines();
      pend = '0; mask = '0; steer = '0; prio = '0;
   endtask

   initial begin
      m_armed = 2'b11; m_out = 2'b00; m_line[0] = 0; m_line[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk("R9 irq low", int'(irq), 0);
      chk("R9 fiq low", int'(fiq), 0);
      chk("R9 irq line", int'(irq_line), 0);
      chk("R9 fiq line", int'(fiq_line), 0);
      // R9: armed at reset, so the first evaluation fires
      pend[7] = 1'b1; prio[7*PW +: PW] = 3'd2;
      pulse(1'b1, 1'b0, 1'b0, "R9 armed after reset");

      // R1 R4 R10: one line at a time over all port positions
      for (int i = 0; i < PL; i++) begin
         clear_lines();
         pend[i] = 1'b1;
         steer[i] = i[0];
         prio[i*PW +: PW] = PW'(i % 8);
         pulse(1'b0, 1'b1, 1'b1, (i < NL) ? "R4 single line" : "R10 upper bank ignored");
      end
      // R1: masked and wrongly steered lines do not compete
      clear_lines();
      pend[12] = 1'b1; mask[12] = 1'b1;
      pend[20] = 1'b1; steer[20] = 1'b1;
      pulse(1'b0, 1'b1, 1'b0, "R1 mask and steering");
      chk("R1 only steered line fires", int'(irq), 0);

      // R2 R3: all 64 priority pairs of lines 5 and 37
      for (int pa = 0; pa < 8; pa++) begin
         for (int pb = 0; pb < 8; pb++) begin
            clear_lines();
            pend[5] = 1'b1; pend[37] = 1'b1;
            prio[5*PW +: PW] = PW'(pa);
            prio[37*PW +: PW] = PW'(pb);
            pulse(1'b0, 1'b1, 1'b0, "R2 pair winner");
            chk("R3 pair arithmetic", int'(irq_line), (pb <= pa) ? 37 : 5);
         end
      end

      // R3: uniform priority levels on random line sets
      for (int k = 0; k < 8; k++) begin
         for (int r = 0; r < 6; r++) begin
            pend = {$urandom, $urandom, $urandom};
            mask = {$urandom, $urandom, $urandom};
            steer = {$urandom, $urandom, $urandom};
            for (int i = 0; i < PL; i++) prio[i*PW +: PW] = PW'(k);
            pulse(1'b0, 1'b1, 1'b1, "R3 tie to larger line");
         end
      end

      // R2: random patterns
      for (int r = 0; r < 150; r++) begin
         pend = {$urandom, $urandom, $urandom};
         mask = {$urandom, $urandom, $urandom};
         steer = {$urandom, $urandom, $urandom};
         for (int i = 0; i < PL; i++) prio[i*PW +: PW] = PW'($urandom);
         pulse(1'b0, 1'b1, 1'b1, "R2 random sweep");
      end

      // R7: arm with nothing pending, then raise a line without any strobe
      clear_lines();
      pulse(1'b0, 1'b1, 1'b1, "R7 arm idle");
      pend[3] = 1'b1; prio[3*PW +: PW] = 3'd5;
      repeat (4) @(negedge clk);
      chk("R7 no fire without strobe", int'(irq), 0);
      pulse(1'b1, 1'b0, 1'b0, "R7 evaluate fires");
      chk("R7 line after evaluate", int'(irq_line), 3);

      // R5: a more urgent line with only an evaluate strobe leaves the result alone
      pend[10] = 1'b1; prio[10*PW +: PW] = 3'd0;
      pulse(1'b1, 1'b0, 1'b0, "R5 one-shot hold");
      chk("R5 line kept", int'(irq_line), 3);
      chk("R5 output kept", int'(irq), 1);
      // R6: rearm now picks the urgent line
      pulse(1'b0, 1'b1, 1'b0, "R6 rearm reevaluates");
      chk("R6 new winner", int'(irq_line), 10);

      // R8: global mask holds back firing, the channel stays armed
      gm = 1'b1;
      pend[40] = 1'b1; steer[40] = 1'b1; prio[40*PW +: PW] = 3'd1;
      pulse(1'b0, 1'b1, 1'b1, "R8 masked globally");
      chk("R8 irq held", int'(irq), 0);
      chk("R8 fiq held", int'(fiq), 0);
      gm = 1'b0;
      pulse(1'b1, 1'b0, 1'b0, "R8 released by evaluate");
      chk("R8 fiq line", int'(fiq_line), 40);
      chk("R8 irq line", int'(irq_line), 10);

      // R11: rearm with nothing competing keeps the old line number
      clear_lines();
      pulse(1'b0, 1'b1, 1'b1, "R11 rearm idle");
      chk("R11 irq line kept", int'(irq_line), 10);
      chk("R11 fiq line kept", int'(fiq_line), 40);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule